// File: doc/BRIEF.md
# Receive Address Remapping Unit

This block rewrites the destination address of each transaction arriving on a receive path before it is handed to the memory system. A 2-bit mode field chooses between leaving the address alone, overwriting chosen bits of the top 12-bit region field with a programmed pattern, and moving the address arithmetically: the column coordinate is taken out of the region field and a 32-bit offset is added. A separate fold input selects the transmit-side option instead. That option makes the two bank bits 17:16 both ones when either of them is set, and both zeros when neither is.

An input is accepted on a clock edge where both the valid input and the enable input are high. The translated address and its valid strobe appear on the registered outputs one edge later, whatever the mode. When nothing is accepted, the valid output falls and the address output keeps its last value. Accepting an address while the reserved mode is selected sets a sticky error flag. Only reset clears it.

Top module: `rx_addr_xlate`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released with no input accepted, outValid is 0, outAddr is 32'h0 and cfgErr is 0.
- R2: An input is accepted at a rising edge where inValid and rxEnable are both 1. At the next sample point, outValid is 1 and outAddr carries the translated address. The latency is one edge in every mode and with fold on or off.
- R3: With rxEnable 0 at an edge, outValid is 0 after that edge and outAddr keeps its previous value, even if inValid is 1.
- R4: With rxMode 2'b00 and foldEn 0, outAddr equals inAddr.
- R5: With rxMode 2'b01 and foldEn 0, outAddr[31:20] = (selMask & patBits) | (~selMask & inAddr[31:20]) and outAddr[19:0] = inAddr[19:0].
- R6: With rxMode 2'b10 and foldEn 0, outAddr = inAddr - (colId << 20) + relocOffset, wrapping modulo 2^32.
- R7: With rxMode 2'b11 and foldEn 0, outAddr equals inAddr and cfgErr is 1 from the same sample point on.
- R8: Once set, cfgErr stays 1 through later accepted inputs in any mode and through idle cycles, until reset.
- R9: With foldEn 1, rxMode is ignored. outAddr equals inAddr except that bits 17:16 are 2'b11 when inAddr[17:16] is nonzero and 2'b00 when it is zero. cfgErr is not set, even with rxMode 2'b11.
- R10: With inValid 0 at an edge, outValid is 0 after that edge and outAddr keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming address is valid |
| inAddr | input | 32 | Incoming destination address |
| rxEnable | input | 1 | Path enable; when 0 no input is accepted |
| rxMode | input | 2 | 00 pass, 01 masked replace, 10 relocate, 11 reserved |
| foldEn | input | 1 | Selects the bank-fold translation instead of rxMode |
| selMask | input | 12 | Per-bit select for the region field replacement |
| patBits | input | 12 | Replacement pattern for the region field |
| relocOffset | input | 32 | Offset added in relocate mode |
| colId | input | 4 | Column coordinate subtracted at bit 20 in relocate mode |
| outValid | output | 1 | Translated address is valid |
| outAddr | output | 32 | Translated address |
| cfgErr | output | 1 | Sticky flag: an input was accepted in the reserved mode |

## Verification
Every translated address and its valid strobe are due exactly one rising edge after the inputs are presented. The error flag follows on the same edge. The bench drives inputs on a falling edge and reads the outputs on the next falling edge, so exactly one rising edge lies between stimulus and sample. Hold behaviour is checked at that same sample point after an edge with the enable or the valid input low, by comparing the address against the value seen one sample earlier. The error flag is checked again after several later edges, which covers its stickiness.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_MASK  = 2'b01,
    MODE_RELOC = 2'b10,
    MODE_RSVD  = 2'b11
  } rxMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic usePass;
    logic useMask;
    logic useReloc;
    logic useFold;
  } xlateStrobe_t;

endpackage

// File: rtl/addr_xlate_ctrl.sv
module addr_xlate_ctrl
  import addr_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         rxEnable,
  input  logic [1:0]   rxMode,
  input  logic         foldEn,
  output xlateStrobe_t strobe,
  output logic         cfgErr
);

  rxMode_e modeSel;
  logic    badMode;

  assign modeSel = rxMode_e'(rxMode);

  always_comb begin
    strobe         = '0;
    strobe.capture = inValid & rxEnable;
    if (foldEn) begin
      strobe.useFold = 1'b1;
    end else begin
      case (modeSel)
        MODE_MASK:  strobe.useMask  = 1'b1;
        MODE_RELOC: strobe.useReloc = 1'b1;
        default:    strobe.usePass  = 1'b1;
      endcase
    end
  end

  assign badMode = strobe.capture & ~foldEn & (modeSel == MODE_RSVD);

  always_ff @(posedge clk) begin
    if (!rstN) cfgErr <= 1'b0;
    else if (badMode) cfgErr <= 1'b1;
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rxEnable && !foldEn && rxMode == 2'b11) |=> cfgErr);

endmodule

// File: rtl/addr_xlate_dp.sv
module addr_xlate_dp
  import addr_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HI_W    = 12,
  parameter int COL_W   = 4,
  parameter int FOLD_LO = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobe_t      strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [HI_W-1:0]   selMask,
  input  logic [HI_W-1:0]   patBits,
  input  logic [ADDR_W-1:0] relocOffset,
  input  logic [COL_W-1:0]  colId,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr
);

  localparam int LO_W = ADDR_W - HI_W;

  logic [HI_W-1:0]   hiRepl;
  logic [ADDR_W-1:0] maskAddr;
  logic [ADDR_W-1:0] colBase;
  logic [ADDR_W-1:0] relocAddr;
  logic [ADDR_W-1:0] foldAddr;
  logic [ADDR_W-1:0] nextAddr;

  for (genvar b = 0; b < HI_W; b++) begin : g_hiBit
    assign hiRepl[b] = selMask[b] ? patBits[b] : inAddr[LO_W + b];
  end

  assign maskAddr  = {hiRepl, inAddr[LO_W-1:0]};
  assign colBase   = ADDR_W'(colId) << LO_W;
  assign relocAddr = inAddr - colBase + relocOffset;

  always_comb begin
    foldAddr = inAddr;
    foldAddr[FOLD_LO+1:FOLD_LO] = {2{|inAddr[FOLD_LO+1:FOLD_LO]}};
  end

  always_comb begin
    if (strobe.useFold)       nextAddr = foldAddr;
    else if (strobe.useMask)  nextAddr = maskAddr;
    else if (strobe.useReloc) nextAddr = relocAddr;
    else                      nextAddr = inAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) outAddr <= nextAddr;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> outValid);

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !outValid);

  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outAddr));

  // R4
  pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.usePass) |=> outAddr == $past(inAddr));

  // R5
  mask_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.useMask) |=> outAddr[LO_W-1:0] == $past(inAddr[LO_W-1:0]));

endmodule

// File: rtl/rx_addr_xlate.sv
module rx_addr_xlate
  import addr_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HI_W    = 12,
  parameter int COL_W   = 4,
  parameter int FOLD_LO = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              rxEnable,
  input  logic [1:0]        rxMode,
  input  logic              foldEn,
  input  logic [HI_W-1:0]   selMask,
  input  logic [HI_W-1:0]   patBits,
  input  logic [ADDR_W-1:0] relocOffset,
  input  logic [COL_W-1:0]  colId,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              cfgErr
);

  xlateStrobe_t strobe;

  addr_xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rxEnable (rxEnable),
    .rxMode   (rxMode),
    .foldEn   (foldEn),
    .strobe   (strobe),
    .cfgErr   (cfgErr)
  );

  addr_xlate_dp #(
    .ADDR_W  (ADDR_W),
    .HI_W    (HI_W),
    .COL_W   (COL_W),
    .FOLD_LO (FOLD_LO)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inAddr      (inAddr),
    .selMask     (selMask),
    .patBits     (patBits),
    .relocOffset (relocOffset),
    .colId       (colId),
    .outValid    (outValid),
    .outAddr     (outAddr)
  );

endmodule

// File: tb/tb_rx_addr_xlate.sv
`timescale 1ns/1ps
module tb_rx_addr_xlate;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] inAddr;
  logic        rxEnable;
  logic [1:0]  rxMode;
  logic        foldEn;
  logic [11:0] selMask;
  logic [11:0] patBits;
  logic [31:0] relocOffset;
  logic [3:0]  colId;
  logic        outValid;
  logic [31:0] outAddr;
  logic        cfgErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rx_addr_xlate dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .rxEnable(rxEnable), .rxMode(rxMode), .foldEn(foldEn),
    .selMask(selMask), .patBits(patBits), .relocOffset(relocOffset),
    .colId(colId), .outValid(outValid), .outAddr(outAddr), .cfgErr(cfgErr)
  );

  // {mode, fold, addr, mask, pat, offset, col, expected}
  localparam logic [126:0] VEC [8] = '{
    {2'b00, 1'b0, 32'h8100_1234, 12'h000, 12'h000, 32'h0000_0000, 4'h0, 32'h8100_1234},
    {2'b01, 1'b0, 32'hABC1_2345, 12'hF00, 12'h5A5, 32'h0000_0000, 4'h0, 32'h5BC1_2345},
    {2'b01, 1'b0, 32'h0000_FFFF, 12'hFFF, 12'h123, 32'h0000_0000, 4'h0, 32'h1230_FFFF},
    {2'b10, 1'b0, 32'h8090_0010, 12'h000, 12'h000, 32'h0000_0100, 4'h3, 32'h8060_0110},
    {2'b10, 1'b0, 32'h0000_0004, 12'h000, 12'h000, 32'h0000_0000, 4'hF, 32'hFF10_0004},
    {2'b10, 1'b0, 32'hFFFF_FFF0, 12'h000, 12'h000, 32'h0000_0020, 4'h0, 32'h0000_0010},
    {2'b00, 1'b1, 32'h1235_5678, 12'h000, 12'h000, 32'h0000_0000, 4'h0, 32'h1237_5678},
    {2'b11, 1'b1, 32'h0002_0000, 12'hFFF, 12'hABC, 32'h1111_1111, 4'h7, 32'h0003_0000}
  };

  function automatic logic [31:0] refXlate(input logic [1:0] m, input logic f,
      input logic [31:0] a, input logic [11:0] sm, input logic [11:0] pt,
      input logic [31:0] off, input logic [3:0] c);
    logic [31:0] r;
    r = a;
    if (f) begin
      r[17:16] = (a[17:16] != 2'b00) ? 2'b11 : 2'b00;
    end else if (m == 2'b01) begin
      r[31:20] = (sm & pt) | (~sm & a[31:20]);
    end else if (m == 2'b10) begin
      r = a + off - {8'h00, c, 20'h00000};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; result read at the next falling edge
  task automatic drive(input logic [1:0] m, input logic f, input logic [31:0] a,
      input logic [11:0] sm, input logic [11:0] pt, input logic [31:0] off,
      input logic [3:0] c);
    inValid = 1'b1; rxEnable = 1'b1;
    rxMode = m; foldEn = f; inAddr = a;
    selMask = sm; patBits = pt; relocOffset = off; colId = c;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] lastAddr;
    rstN = 1'b0; inValid = 1'b0; rxEnable = 1'b0; rxMode = 2'b00; foldEn = 1'b0;
    inAddr = '0; selMask = '0; patBits = '0; relocOffset = '0; colId = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", {31'b0, outValid}, 32'h0);
    check("R1 outAddr", outAddr, 32'h0);
    check("R1 cfgErr", {31'b0, cfgErr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'b0, outValid}, 32'h0);

    // table walk: R4 R5 R6 R9 and R2 latency
    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][126:125], VEC[i][124], VEC[i][123:92], VEC[i][91:80],
            VEC[i][79:68], VEC[i][67:36], VEC[i][35:32]);
      check($sformatf("R2 valid vec%0d", i), {31'b0, outValid}, 32'h1);
      check($sformatf("R4/R5/R6/R9 addr vec%0d", i), outAddr, VEC[i][31:0]);
    end
    // R9 fold with reserved mode leaves flag clear
    check("R9 no cfgErr", {31'b0, cfgErr}, 32'h0);

    // R10 idle input holds
    lastAddr = outAddr;
    inAddr = 32'h5555_AAAA;
    @(negedge clk);
    check("R10 valid low", {31'b0, outValid}, 32'h0);
    check("R10 addr held", outAddr, lastAddr);

    // R3 enable low ignores valid input
    inValid = 1'b1; rxEnable = 1'b0; rxMode = 2'b00; foldEn = 1'b0; inAddr = 32'h1357_9BDF;
    @(negedge clk);
    check("R3 valid low", {31'b0, outValid}, 32'h0);
    check("R3 addr held", outAddr, lastAddr);
    inValid = 1'b0;

    // R2 back-to-back accepts
    drive(2'b00, 1'b0, 32'h0000_0001, 12'h0, 12'h0, 32'h0, 4'h0);
    check("R2 b2b first", outAddr, 32'h0000_0001);
    drive(2'b10, 1'b0, 32'h0050_0000, 12'h0, 12'h0, 32'h0, 4'h5);
    check("R2 b2b second", outAddr, 32'h0000_0000);

    // R7 reserved mode
    drive(2'b11, 1'b0, 32'hDEAD_BEEF, 12'hFFF, 12'h000, 32'h1, 4'h1);
    check("R7 addr pass", outAddr, 32'hDEAD_BEEF);
    check("R7 cfgErr set", {31'b0, cfgErr}, 32'h1);

    // R8 sticky
    drive(2'b00, 1'b0, 32'h0000_0002, 12'h0, 12'h0, 32'h0, 4'h0);
    repeat (4) @(negedge clk);
    check("R8 sticky", {31'b0, cfgErr}, 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset clears cfgErr", {31'b0, cfgErr}, 32'h0);
    check("R1 reset clears addr", outAddr, 32'h0);

    // random sweep against model
    for (int k = 0; k < 300; k++) begin
      logic [1:0]  m;
      logic        f;
      logic [31:0] a, off;
      logic [11:0] sm, pt;
      logic [3:0]  c;
      m = 2'($urandom); f = ($urandom % 4) == 0; a = $urandom;
      sm = 12'($urandom); pt = 12'($urandom); off = $urandom; c = 4'($urandom);
      drive(m, f, a, sm, pt, off, c);
      check($sformatf("R4/R5/R6/R7/R9 rand%0d", k), outAddr, refXlate(m, f, a, sm, pt, off, c));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule